// File: doc/BRIEF.md
# Five-Code Self-Recovering Sequence Counter

This block is a 3-bit state machine. On each enabled clock it steps through a fixed cycle of five codes that do not follow binary order. The three codes outside the cycle are never produced while the counter runs normally. If the register wakes up holding one of them, or is loaded with one, the counter returns to the cycle within two enabled steps. A synchronous load port can force any value into the register. Test logic uses it to reach the unused codes and to preset a starting point.

The state is read out as a 3-bit word. Bit 2 is called C, bit 1 is B and bit 0 is A. The next state is given by three fixed equations: C takes the value of A, B becomes (not B) or (not A and not C), and A becomes (B and not C). The design has a synchronous active-low reset that returns it to 000.

Top module: `seqfive_counter`

## Requirements
- R1: While rst_n is low at a rising clock edge, the state becomes 000.
- R2: With enable high and load low, the state advances 000→010→011→101→110→000. State bits are {C,B,A}, with C at bit 2.
- R3: With enable high and no load, the state returns to its starting value after exactly five steps.
- R4: With enable low and load low, the state holds its value.
- R5: When load is high, the state takes load_val on the next edge whatever enable is. This includes the unused codes 001, 100 and 111.
- R6: Unused code 001 steps to 110.
- R7: Unused code 100 steps to 010.
- R8: Unused code 111 steps to 100 and then to 010. No unused code needs more than two enabled steps to reach the cycle.
- R9: Starting from any valid code, the state never takes an unused code except through load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Advance one step per clock when high |
| load | input | 1 | Synchronous load, takes priority over enable |
| load_val | input | 3 | Value written on load |
| state | output | 3 | Current code {C,B,A} |

## Verification
Long runs with enable held high check the exact order of the five codes and the period of five. Random patterns on enable separate a correct hold from a skipped step or a double step. Load is applied to each unused code and then followed by enabled steps, which tells apart the three recovery paths, including the two-step path from 111. Load is also applied with enable low, and together with these cases this shows that load takes priority over enable.

// File: rtl/seqfive_pkg.sv
// Shared width and named codes for the five-code counter.
package seqfive_pkg;
    localparam int unsigned STATE_W = 3;
    typedef logic [STATE_W-1:0] code_t;
    localparam code_t CODE_RESET = 3'b000;
endpackage

// File: rtl/seqfive_next.sv
// Combinational next-state function of the five-code cycle.
// Assumes: code bit 2 is C, bit 1 is B, bit 0 is A. It is defined for
// all 8 inputs, so unused codes lead back into the cycle.
module seqfive_next
    import seqfive_pkg::*;
(
    input  code_t cur,
    output code_t nxt
);
    logic c, b, a;
    // Split the code into named bits and apply the equations.
    always_comb begin
        c = cur[2];
        b = cur[1];
        a = cur[0];
        nxt[2] = a;
        nxt[1] = ~b | (~a & ~c);
        nxt[0] = b & ~c;
    end
endmodule

// File: rtl/seqfive_counter.sv
// Top level: state register with synchronous reset, load and enable.
// Assumes: load has priority over enable; rst_n is active low and synchronous.
module seqfive_counter
    import seqfive_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       load,
    input  logic [2:0] load_val,
    output logic [2:0] state
);
    code_t cur_q, step_d;

    seqfive_next u_next (.cur(cur_q), .nxt(step_d));

    // State register update, in priority order: reset, load, enable, hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      cur_q <= CODE_RESET;
        else if (load)   cur_q <= load_val;
        else if (enable) cur_q <= step_d;
    end

    assign state = cur_q;

    function automatic logic is_valid(input code_t v);
        return (v == 3'b000) || (v == 3'b010) || (v == 3'b011) ||
               (v == 3'b101) || (v == 3'b110);
    endfunction

    // R1: reset drives the state to zero.
    a_r1_reset: assert property (@(posedge clk)
        !rst_n |=> state == 3'b000);
    // R4: hold when idle.
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !enable) |=> $stable(state));
    // R5: load wins.
    a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> state == $past(load_val));
    // R9: valid codes stay valid.
    a_r9_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && is_valid(state)) |=> is_valid(state));
    // R8: 111 recovers to 100.
    a_r8_from7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && enable && state == 3'b111) |=> state == 3'b100);
    // R6: 001 goes to 110.
    a_r6_from1: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && enable && state == 3'b001) |=> state == 3'b110);
endmodule

// File: tb/sim_seqfive_counter.sv
module sim_seqfive_counter;
    logic clk = 0, rst_n = 0, enable = 0, load = 0;
    logic [2:0] load_val = 0;
    logic [2:0] state;
    int vectors = 0, errors = 0;
    int model;

    seqfive_counter u0 (.clk(clk), .rst_n(rst_n), .enable(enable),
                        .load(load), .load_val(load_val), .state(state));

    always #10 clk = ~clk;

    function automatic int succ(input int v);
        case (v)
            0: return 2;  2: return 3;  3: return 5;  5: return 6;  6: return 0;
            1: return 6;  4: return 2;  7: return 4;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input int exp, input string req);
        vectors++;
        if (state !== exp[2:0]) begin
            errors++;
            $display("FAIL %s: state=%b expected=%b", req, state, exp[2:0]);
        end
    endtask

    // One clock with model update, then check at the negedge.
    task automatic step(input logic en, input logic ld, input int lv, input string req);
        enable = en; load = ld; load_val = lv[2:0];
        @(posedge clk);
        if (!rst_n) model = 0;
        else if (ld) model = lv;
        else if (en) model = succ(model);
        @(negedge clk);
        chk(model, req);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: state=%b expected=done", state);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        model = 0;
        @(negedge clk);
        step(1, 0, 0, "R1");
        rst_n = 1;
        // R2: the full sequence
        for (int i = 0; i < 10; i++) step(1, 0, 0, "R2");
        // R3: period of five, starting from each valid code
        for (int s = 0; s < 5; s++) begin
            int start;
            start = model;
            for (int k = 0; k < 5; k++) step(1, 0, 0, "R3");
            vectors++;
            if (state !== start[2:0]) begin
                errors++;
                $display("FAIL R3: state=%b expected=%b", state, start[2:0]);
            end
            step(1, 0, 0, "R2");
        end
        // R4: hold
        for (int i = 0; i < 4; i++) step(0, 0, 0, "R4");
        // R5: load wins over enable, every value
        for (int v = 0; v < 8; v++) begin
            step(v[0], 1, v, "R5");
            step(0, 0, 0, "R4");
        end
        // R6, R7, R8: recovery from each unused code
        step(0, 1, 1, "R5"); step(1, 0, 0, "R6"); step(1, 0, 0, "R6");
        step(0, 1, 4, "R5"); step(1, 0, 0, "R7"); step(1, 0, 0, "R7");
        step(0, 1, 7, "R5"); step(1, 0, 0, "R8"); step(1, 0, 0, "R8");
        step(1, 0, 0, "R8");
        // R9: random enable patterns
        for (int i = 0; i < 200; i++) step(($urandom % 3) != 0, 0, 0, "R9");
        // R1 again, mid-run
        rst_n = 0;
        step(1, 0, 5, "R1");
        rst_n = 1;
        step(1, 0, 0, "R2");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule